// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block turns interrupt events from on-chip sources into fixed 16-byte vectors and stores them, one dword at a time, into a circular buffer in system memory. Software programs the ring through a small register file: a control word, a ring base, a read pointer, a write pointer and a write-pointer copy-out address. While the ring holds unread vectors, or after it has overrun, the block raises a host interrupt. Software drains vectors up to the write pointer and then moves the read pointer forward.

Both pointers are byte offsets that wrap at the programmed ring size. When a store catches up with the read pointer, the block flags an overrun in bit 0 of the write-pointer readback and keeps storing, overwriting the oldest entries. Software clears that flag through a write-one bit in the control word. As an option, the block copies the write-pointer readback to a memory address after each vector. This lets software poll memory instead of the register.

Events wait in a small input queue. The memory side is a single dword write port with a valid/ready handshake.

Top module: `ivring_writer`

## Requirements
- R1: After reset, both pointers read 0, `host_irq`, `busy` and `mem_valid` are low, and `ev_ready` is high.
- R2: Register offsets on `cfg_addr` are 0 control, 1 ring base (byte address bits 39:8), 2 read pointer, 3 write pointer, 4 copy-out address bits 31:0, and 5 copy-out address bits 39:32 (data bits 7:0). Control bits are: bit 0 ring enable, bits 5:1 ring size as log2 of its dword count, bit 8 copy-out enable, bit 17 interrupt enable, bit 21 re-arm and bit 31 overrun clear. `cfg_rdata` shows the addressed register combinationally.
- R3: Each vector is four dword writes to base*256 + wptr + 0, 4, 8 and 12, in that order. Dword 0 holds the source id in bits 7:0. Dword 1 holds the 28-bit source data. Dword 2 holds the ring id in bits 7:0, the VM id in bits 15:8 and the address-space id in bits 31:16. Dword 3 is zero. All unused bits are zero.
- R4: The write pointer advances by 16 per stored vector, modulo (4 << size) bytes.
- R5: If a stored vector makes the write pointer equal to the read pointer, bit 0 of the write-pointer readback becomes 1. Later vectors are still written, overwriting the oldest ones.
- R6: Writing the control word with bit 31 set clears the overrun flag. Bit 31 always reads back as 0.
- R7: `host_irq` is high when interrupt enable is set and either the pointers differ or the overrun flag is set. It is low otherwise.
- R8: With re-arm set, a read-pointer write drops `host_irq` for exactly the next cycle, after which it follows R7.
- R9: With copy-out enabled, each vector is followed by one more dword write. It carries the write-pointer readback, including bit 0, to the copy-out address with its low two bits forced to zero.
- R10: With ring enable clear, no vector is written and accepted events stay queued. They are written in arrival order once the ring is enabled. Writes to either pointer register are visible on readback the next cycle.
- R11: A read-pointer write keeps only the bits inside the ring size and clears bits 3:0.
- R12: `ev_ready` is low while 4 events are queued, and also while `mem_valid` is high and `mem_ready` is low.
- R13: `busy` is high while any queued vector or pending copy-out has not been accepted by memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event taken this cycle when valid |
| ev_src | input | 8 | Source id |
| ev_data | input | 28 | Source data |
| ev_ring | input | 8 | Ring id |
| ev_vm | input | 8 | VM id |
| ev_asid | input | 16 | Address-space id |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| mem_valid | output | 1 | Dword write request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 40 | Byte address of the dword |
| mem_data | output | 32 | Dword to write |
| host_irq | output | 1 | Host interrupt level |
| busy | output | 1 | Work outstanding |

## Verification
The bench drives the ring through a full wrap with a 64-byte ring, so the fourth vector lands on the read pointer. A design that compared against the wrong pointer, or stopped writing on overrun, would either miss the bit 0 flag or leave the wrapped vector at the wrong address. It checks that a read-pointer write with stray low bits is trimmed; a design that kept them would never see the ring as empty. It also checks the one-cycle interrupt gap on re-arm, where an off-by-one would hold the line low too long or not at all. Events are queued while the ring is disabled and the memory stalls, and the bench then checks the order, the queue-full backpressure and the copy-out dword carrying the flag.

// File: rtl/ivring_writer.sv
module ivring_writer #(
  parameter int PW     = 20,
  parameter int QDEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_valid,
  output logic        ev_ready,
  input  logic [7:0]  ev_src,
  input  logic [27:0] ev_data,
  input  logic [7:0]  ev_ring,
  input  logic [7:0]  ev_vm,
  input  logic [15:0] ev_asid,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic [39:0] mem_addr,
  output logic [31:0] mem_data,
  output logic        host_irq,
  output logic        busy
);
  localparam int QAW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int EW  = 68;

  typedef enum logic [1:0] {S_IDLE, S_VEC, S_WB} state_t;

  logic          en_q, wb_q, ie_q, rearm_q, ovf_q, gap_q;
  logic [4:0]    size_q;
  logic [31:0]   base_q;
  logic [31:2]   wbl_q;
  logic [7:0]    wbh_q;
  logic [PW-1:0] rptr_q, wptr_q, amask, nxt;
  state_t        state_q;
  logic [1:0]    beat_q;

  logic [EW-1:0] qmem [QDEPTH];
  logic [QAW-1:0] qwr_q, qrd_q;
  logic [QAW:0]   qcnt_q;
  logic [EW-1:0]  head;
  logic           push, pop, acc, qfull;

  assign amask    = PW'((33'd4 << size_q) - 33'd1) & ~PW'(15);
  assign nxt      = (wptr_q + PW'(16)) & amask;
  assign qfull    = (qcnt_q == (QAW+1)'(QDEPTH));
  assign mem_valid = (state_q != S_IDLE);
  assign acc      = mem_valid && mem_ready;
  assign ev_ready = !qfull && !(mem_valid && !mem_ready);
  assign push     = ev_valid && ev_ready;
  assign pop      = acc && (state_q == S_VEC) && (beat_q == 2'd3);
  assign head     = qmem[qrd_q];
  assign busy     = (qcnt_q != '0) || (state_q != S_IDLE);
  assign host_irq = ie_q && ((rptr_q != wptr_q) || ovf_q) && !gap_q;

  assign mem_addr = (state_q == S_WB) ? {wbh_q, wbl_q, 2'b00}
                  : {base_q, 8'h00} + 40'(wptr_q) + {36'd0, beat_q, 2'b00};

  always_comb begin
    case (beat_q)
      2'd0:    mem_data = {24'd0, head[67:60]};
      2'd1:    mem_data = {4'd0, head[59:32]};
      2'd2:    mem_data = head[31:0];
      default: mem_data = 32'd0;
    endcase
    if (state_q == S_WB) mem_data = 32'(wptr_q) | {31'd0, ovf_q};
  end

  always_comb begin
    case (cfg_addr)
      3'd0: cfg_rdata = {10'd0, rearm_q, 3'd0, ie_q, 8'd0, wb_q, 2'd0, size_q, en_q};
      3'd1: cfg_rdata = base_q;
      3'd2: cfg_rdata = 32'(rptr_q);
      3'd3: cfg_rdata = 32'(wptr_q) | {31'd0, ovf_q};
      3'd4: cfg_rdata = {wbl_q, 2'b00};
      3'd5: cfg_rdata = {24'd0, wbh_q};
      default: cfg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) qmem[qwr_q] <= {ev_src, ev_data, ev_asid, ev_vm, ev_ring};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      qwr_q <= '0; qrd_q <= '0; qcnt_q <= '0;
    end else begin
      if (push) qwr_q <= (qwr_q == QAW'(QDEPTH-1)) ? '0 : qwr_q + 1'b1;
      if (pop)  qrd_q <= (qrd_q == QAW'(QDEPTH-1)) ? '0 : qrd_q + 1'b1;
      qcnt_q <= qcnt_q + (QAW+1)'(push) - (QAW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; wb_q <= 1'b0; ie_q <= 1'b0; rearm_q <= 1'b0; size_q <= '0;
      base_q <= '0; wbl_q <= '0; wbh_q <= '0;
      rptr_q <= '0; wptr_q <= '0; ovf_q <= 1'b0; gap_q <= 1'b0;
      state_q <= S_IDLE; beat_q <= '0;
    end else begin
      gap_q <= 1'b0;
      case (state_q)
        S_IDLE: if (en_q && qcnt_q != '0) state_q <= S_VEC;
        S_VEC: if (acc) begin
          beat_q <= beat_q + 2'd1;
          if (beat_q == 2'd3) begin
            wptr_q <= nxt;
            if (nxt == rptr_q) ovf_q <= 1'b1;
            state_q <= wb_q ? S_WB : S_IDLE;
          end
        end
        default: if (acc) state_q <= S_IDLE;
      endcase
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: begin
            en_q <= cfg_wdata[0]; size_q <= cfg_wdata[5:1]; wb_q <= cfg_wdata[8];
            ie_q <= cfg_wdata[17]; rearm_q <= cfg_wdata[21];
            if (cfg_wdata[31]) ovf_q <= 1'b0;
          end
          3'd1: base_q <= cfg_wdata;
          3'd2: begin
            rptr_q <= PW'(cfg_wdata) & amask;
            if (rearm_q) gap_q <= 1'b1;
          end
          3'd3: wptr_q <= PW'(cfg_wdata) & amask;
          3'd4: wbl_q <= cfg_wdata[31:2];
          3'd5: wbh_q <= cfg_wdata[7:0];
          default: ;
        endcase
      end
    end
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  assert_dword_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);
  assert_wptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) && $changed(wptr_q) |-> wptr_q == (($past(wptr_q) + PW'(16)) & amask));
  assert_quiet_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rptr_q == wptr_q) && !ovf_q |-> !host_irq);
  assert_full_backpressure_R12: assert property (@(posedge clk) disable iff (!rst_n)
    qfull |-> !ev_ready);
  assert_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);
endmodule

// File: tb/ivring_writer_bench.sv
module ivring_writer_bench;
  localparam int CLK = 10;
  localparam logic [31:0] EN = 32'h1, SZ4 = 32'h8, WB = 32'h100, IE = 32'h2_0000,
                          RA = 32'h20_0000, CLR = 32'h8000_0000;

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, ev_ready;
  logic [7:0] ev_src = 0, ev_ring = 0, ev_vm = 0;
  logic [27:0] ev_data = 0;
  logic [15:0] ev_asid = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic mem_valid, mem_ready = 1;
  logic [39:0] mem_addr;
  logic [31:0] mem_data;
  logic host_irq, busy;

  int n_run = 0, n_fail = 0, lg_n = 0;
  logic [39:0] lg_addr [256];
  logic [31:0] lg_data [256];

  ivring_writer u_ivring_writer (.*);

  always #(CLK/2) clk = ~clk;

  always @(negedge clk)
    if (rst_n && mem_valid && mem_ready && lg_n < 256) begin
      lg_addr[lg_n] = mem_addr; lg_data[lg_n] = mem_data; lg_n++;
    end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #1 cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1 cfg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic send(logic [7:0] s, logic [27:0] dt, logic [7:0] r, logic [7:0] v, logic [15:0] as);
    @(posedge clk); #1 ev_valid = 1; ev_src = s; ev_data = dt; ev_ring = r; ev_vm = v; ev_asid = as;
    forever begin @(negedge clk); if (ev_ready) break; end
    @(posedge clk); #1 ev_valid = 0;
  endtask

  task automatic idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    @(negedge clk);
    rd(3, d); chk("R1 wptr", d, 0);
    rd(2, d); chk("R1 rptr", d, 0);
    chk("R1 irq/busy/valid/ready", {host_irq, busy, mem_valid, ev_ready}, 4'b0001);
  endtask

  task automatic t_pack();
    logic [31:0] d;
    wr(1, 32'h12345); wr(0, EN | SZ4 | IE);
    rd(0, d); chk("R2 control readback", d, EN | SZ4 | IE);
    send(8'hA5, 28'hBCDEF12, 8'h3C, 8'h7E, 16'hBEEF);
    idle();
    chk("R3 count", lg_n, 4);
    for (int i = 0; i < 4; i++) chk("R3 addr", lg_addr[i], 40'h12345_00 + 40'(4*i));
    chk("R3 dw0", lg_data[0], 32'hA5);
    chk("R3 dw1", lg_data[1], 32'h0BCDEF12);
    chk("R3 dw2", lg_data[2], 32'hBEEF7E3C);
    chk("R3 dw3", lg_data[3], 0);
    rd(3, d); chk("R4 wptr after one", d, 16);
    chk("R7 irq pending", host_irq, 1);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    send(1, 0, 0, 0, 0); send(2, 0, 0, 0, 0); idle();
    rd(3, d); chk("R4 wptr 48", d, 48);
    send(3, 0, 0, 0, 0); idle();
    chk("R5 fourth addr", lg_addr[12], 40'h12345_30);
    rd(3, d); chk("R5 overrun flag", d, 32'h1);
    send(4, 0, 0, 0, 0); idle();
    chk("R4 wrap addr", lg_addr[16], 40'h12345_00);
    chk("R5 overwrite data", lg_data[16], 4);
    rd(3, d); chk("R5 flag kept", d, 32'h11);
    chk("R7 irq on overrun", host_irq, 1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(0, EN | SZ4 | IE | CLR);
    rd(3, d); chk("R6 flag cleared", d, 32'h10);
    rd(0, d); chk("R6 bit31 reads 0", d[31], 0);
    wr(2, 32'hFFF7);
    rd(2, d); chk("R11 rptr trimmed", d, 32'h30);
    @(negedge clk); chk("R7 irq differ", host_irq, 1);
    wr(2, 16); @(negedge clk); chk("R7 irq empty", host_irq, 0);
  endtask

  task automatic t_rearm();
    wr(0, EN | SZ4 | IE | RA);
    wr(2, 32'h20);
    @(negedge clk); chk("R8 gap cycle", host_irq, 0);
    @(negedge clk); chk("R8 after gap", host_irq, 1);
  endtask

  task automatic t_wb();
    int base;
    wr(2, 16); wr(4, 32'h1003); wr(5, 32'h2);
    wr(0, EN | SZ4 | IE | WB);
    base = lg_n;
    send(8'h11, 28'h5, 8'h1, 8'h2, 16'h3); idle();
    chk("R9 count", lg_n - base, 5);
    chk("R9 addr", lg_addr[base+4], 40'h02_0000_1000);
    chk("R9 data", lg_data[base+4], 32'h20);
    chk("R3 at wptr 16", lg_addr[base], 40'h12345_10);
  endtask

  task automatic t_queue();
    logic [31:0] d;
    int base;
    wr(0, SZ4); wr(2, 0); wr(3, 0);
    rd(2, d); chk("R10 rptr zero", d, 0);
    rd(3, d); chk("R10 wptr zero", d, 0);
    base = lg_n;
    for (int i = 0; i < 4; i++) send(8'(8'h40 + i), 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R12 full", ev_ready, 0);
    chk("R13 busy queued", busy, 1);
    chk("R10 no writes while disabled", lg_n - base, 0);
    wr(0, EN | SZ4); idle();
    chk("R10 drained", lg_n - base, 16);
    for (int i = 0; i < 4; i++) begin
      chk("R10 order", lg_data[base + 4*i], 32'(8'h40 + i));
      chk("R10 addr", lg_addr[base + 4*i], 40'h12345_00 + 40'(16*i));
    end
    rd(3, d); chk("R5 flag after fill", d, 32'h1);
    chk("R13 idle", busy, 0);
    @(posedge clk); #1 mem_ready = 0;
    send(8'h77, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R12 stall", {mem_valid, ev_ready}, 2'b10);
    @(posedge clk); #1 mem_ready = 1;
    idle();
    chk("R3 after stall", lg_addr[lg_n-4], 40'h12345_00);
  endtask

  initial begin
    #(CLK*150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset(); t_pack(); t_wrap(); t_clear(); t_rearm(); t_wb(); t_queue();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule